// File: doc/BRIEF.md
# Dual-Mode Frequency Transition Sequencer

This block sits on the platform side of a processor that has two operating points. One is a low-frequency battery mode and the other is a high-frequency performance mode. A one-cycle request pulse names the wanted mode. The sequencer then drives the active-low mode-select line to match that mode and asks the processor into Deep Sleep. After that it gates the bus clock off and waits for the regulator to report power-good at a new voltage ID. It then restarts the clock, releases the sleep request and reports the new mode.

While the processor sleeps, the block holds its bus-side outputs frozen and raises a busy flag. If the regulator never confirms a new voltage ID, a timeout aborts the change: the old mode is restored, the processor is woken cleanly and an error flag is set. An optional deeper step adds a low-voltage request for the whole sleep window. Each timed step lasts `STEP_CYCLES` clock cycles, with a default of 16. The voltage wait is bounded by `VR_TIMEOUT` cycles, with a default of 1024.

Top module: `dual_mode_seq`

## Requirements
- R1: After reset the block is in battery mode: `mode_sel_n`=1, `sleep_req_n`=1, `bclk_en`=1, `mode_perf`=0, `busy`=0, `err`=0, `vr_lowv_req`=0.
- R2: A `req_valid` pulse with `req_perf`=1 while in battery mode drives `mode_sel_n` low in the next cycle, before `sleep_req_n` is asserted. The full sleep, clock-stop, voltage wait, restart and wake sequence follows, and `mode_perf` then reads 1.
- R3: A `req_valid` pulse with `req_perf`=0 while in performance mode runs the same sequence with `mode_sel_n` driven high, and `mode_perf` then reads 0.
- R4: `bclk_en` falls only while `sleep_req_n` is low and has been low for at least one earlier cycle. It is high again at least one cycle before `sleep_req_n` returns high.
- R5: While the clock is gated off, `bclk_p` is held at 0 and `bclk_n` at 1.
- R6: `busy` is high from the cycle `sleep_req_n` is asserted until `STEP_CYCLES` cycles after it is released. While `busy` is high, `bus_out` keeps its value. Otherwise `bus_out` follows `bus_in` one cycle later.
- R7: `vr_vid` follows `vid_in` one cycle later. The voltage wait ends only when `vr_pgood`=1 and `vid_in` differs from the value sampled when the request was accepted.
- R8: If `deeper_en`=1 when the request is accepted, `vr_lowv_req` is high exactly while `sleep_req_n` is low. Otherwise it stays 0.
- R9: If the voltage wait is not satisfied within `VR_TIMEOUT` cycles, `err` goes to 1 and `mode_sel_n` returns to its old level. The clock is restarted, the sleep request is released and `mode_perf` is unchanged. `err` clears when the next request is accepted.
- R10: A request for the mode already active completes without asserting `sleep_req_n`, and `mode_perf` is unchanged.
- R11: A request that arrives during a transition is ignored and is not queued.
- R12: `mode_perf` changes only after the wake sequence completes. It keeps its old value throughout the sleep window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle mode change request |
| req_perf | input | 1 | Requested mode: 1 performance, 0 battery |
| deeper_en | input | 1 | Add the low-voltage request to this transition |
| vid_in | input | VID_W | Voltage ID driven by the processor |
| vr_pgood | input | 1 | Regulator power-good |
| bus_in | input | BUS_W | System-bus side signals to pass through |
| mode_sel_n | output | 1 | Active-low performance mode select |
| sleep_req_n | output | 1 | Active-low Deep Sleep request |
| bclk_en | output | 1 | Bus clock gate enable |
| bclk_p | output | 1 | True bus clock output |
| bclk_n | output | 1 | Complementary bus clock output |
| vr_vid | output | VID_W | Voltage ID forwarded to the regulator |
| vr_lowv_req | output | 1 | Low-voltage request for the deeper step |
| bus_out | output | BUS_W | Bus-side outputs, frozen while busy |
| busy | output | 1 | Sleep window in progress |
| err | output | 1 | Last transition timed out |
| mode_perf | output | 1 | Current mode status: 1 performance |

## Verification
The bench first checks ordering on the sleep edges. A design that gated the clock in the same cycle as the sleep request, or released sleep before the clock ran, would trip the clock-gating checks. It holds `vr_pgood` low after a voltage ID change, and then raises power-good with an unchanged ID. A design that woke on only one of the two conditions would restart the clock early. It lets the timeout expire and checks that the mode-select line and the status are both restored. A design that kept the new mode or left the clock stopped would fail there. It also sends a same-mode request and a request in the middle of a transition. Either one would show a stray sleep window if the design queued or acted on it.

// File: rtl/dual_mode_seq_pkg.sv
package dual_mode_seq_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL      = 3'd0,
        ST_ENTER_SLEEP = 3'd1,
        ST_CLK_STOPPED = 3'd2,
        ST_WAIT_VR     = 3'd3,
        ST_CLK_RESTART = 3'd4,
        ST_EXIT_SLEEP  = 3'd5,
        ST_DONE        = 3'd6
    } seq_state_e;

endpackage

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
    parameter int STEP_CYCLES = 16,
    parameter int VR_TIMEOUT  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic step_done,
    output logic tmo_done
);
    localparam int CW = $clog2(VR_TIMEOUT + 1);
    localparam logic [CW-1:0] STEP_LAST = CW'(STEP_CYCLES - 1);
    localparam logic [CW-1:0] TMO_LAST  = CW'(VR_TIMEOUT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q == TMO_LAST) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign step_done = (cnt_q >= STEP_LAST);
    assign tmo_done  = (cnt_q == TMO_LAST);
endmodule

// File: rtl/bus_clk_gen.sv
module bus_clk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bclk_p,
    output logic bclk_n
);
    logic p_d, p_q;

    always_comb begin
        p_d = en ? ~p_q : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign bclk_p = p_q;
    assign bclk_n = ~p_q;
endmodule

// File: rtl/dual_mode_seq.sv
module dual_mode_seq
    import dual_mode_seq_pkg::*;
#(
    parameter int VID_W       = 5,
    parameter int BUS_W       = 8,
    parameter int STEP_CYCLES = 16,
    parameter int VR_TIMEOUT  = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_perf,
    input  logic             deeper_en,
    input  logic [VID_W-1:0] vid_in,
    input  logic             vr_pgood,
    input  logic [BUS_W-1:0] bus_in,
    output logic             mode_sel_n,
    output logic             sleep_req_n,
    output logic             bclk_en,
    output logic             bclk_p,
    output logic             bclk_n,
    output logic [VID_W-1:0] vr_vid,
    output logic             vr_lowv_req,
    output logic [BUS_W-1:0] bus_out,
    output logic             busy,
    output logic             err,
    output logic             mode_perf
);
    typedef struct packed {
        seq_state_e       state;
        logic             target;
        logic             mode;
        logic             sel_n;
        logic             sleep_n;
        logic             clk_en;
        logic             lowv;
        logic             deeper;
        logic             busy;
        logic             err;
        logic             fail;
        logic [VID_W-1:0] vid_old;
        logic [VID_W-1:0] vid_fwd;
        logic [BUS_W-1:0] bus;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;
    logic      tmr_clr, step_done, tmo_done;

    seq_step_timer #(
        .STEP_CYCLES (STEP_CYCLES),
        .VR_TIMEOUT  (VR_TIMEOUT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tmr_clr),
        .step_done (step_done),
        .tmo_done  (tmo_done)
    );

    bus_clk_gen u_bclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cur_q.clk_en),
        .bclk_p (bclk_p),
        .bclk_n (bclk_n)
    );

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.vid_fwd = vid_in;
        if (!cur_q.busy) begin
            nxt_d.bus = bus_in;
        end
        unique case (cur_q.state)
            ST_NORMAL: begin
                if (req_valid) begin
                    nxt_d.target = req_perf;
                    if (req_perf == cur_q.mode) begin
                        nxt_d.state = ST_DONE;
                    end else begin
                        nxt_d.sel_n   = ~req_perf;
                        nxt_d.deeper  = deeper_en;
                        nxt_d.vid_old = vid_in;
                        nxt_d.err     = 1'b0;
                        nxt_d.fail    = 1'b0;
                        nxt_d.state   = ST_ENTER_SLEEP;
                    end
                end
            end
            ST_ENTER_SLEEP: begin
                if (step_done) begin
                    nxt_d.sleep_n = 1'b0;
                    nxt_d.busy    = 1'b1;
                    nxt_d.lowv    = cur_q.deeper;
                    nxt_d.state   = ST_CLK_STOPPED;
                end
            end
            ST_CLK_STOPPED: begin
                if (step_done) begin
                    nxt_d.clk_en = 1'b0;
                    nxt_d.state  = ST_WAIT_VR;
                end
            end
            ST_WAIT_VR: begin
                if (step_done && vr_pgood && (vid_in != cur_q.vid_old)) begin
                    nxt_d.clk_en = 1'b1;
                    nxt_d.state  = ST_CLK_RESTART;
                end else if (tmo_done) begin
                    nxt_d.clk_en = 1'b1;
                    nxt_d.sel_n  = ~cur_q.mode;
                    nxt_d.err    = 1'b1;
                    nxt_d.fail   = 1'b1;
                    nxt_d.state  = ST_CLK_RESTART;
                end
            end
            ST_CLK_RESTART: begin
                if (step_done) begin
                    nxt_d.sleep_n = 1'b1;
                    nxt_d.lowv    = 1'b0;
                    nxt_d.state   = ST_EXIT_SLEEP;
                end
            end
            ST_EXIT_SLEEP: begin
                if (step_done) begin
                    nxt_d.busy  = 1'b0;
                    nxt_d.state = cur_q.fail ? ST_NORMAL : ST_DONE;
                end
            end
            ST_DONE: begin
                nxt_d.mode  = cur_q.target;
                nxt_d.state = ST_NORMAL;
            end
            default: nxt_d.state = ST_NORMAL;
        endcase
        tmr_clr = (nxt_d.state != cur_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q         <= '0;
            cur_q.state   <= ST_NORMAL;
            cur_q.sel_n   <= 1'b1;
            cur_q.sleep_n <= 1'b1;
            cur_q.clk_en  <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mode_sel_n  = cur_q.sel_n;
    assign sleep_req_n = cur_q.sleep_n;
    assign bclk_en     = cur_q.clk_en;
    assign vr_vid      = cur_q.vid_fwd;
    assign vr_lowv_req = cur_q.lowv;
    assign bus_out     = cur_q.bus;
    assign busy        = cur_q.busy;
    assign err         = cur_q.err;
    assign mode_perf   = cur_q.mode;
endmodule

// File: rtl/dual_mode_seq_chk.sv
module dual_mode_seq_chk #(
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_req_n,
    input logic             bclk_en,
    input logic             bclk_p,
    input logic             bclk_n,
    input logic             vr_lowv_req,
    input logic [BUS_W-1:0] bus_out,
    input logic             busy,
    input logic             mode_perf
);
    assert_gate_after_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk_en) |-> (!sleep_req_n && $past(!sleep_req_n)));

    assert_run_before_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req_n) |-> (bclk_en && $past(bclk_en)));

    assert_gate_only_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_en |-> !sleep_req_n);

    assert_clk_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk_en && $past(!bclk_en)) |-> (!bclk_p && bclk_n));

    assert_bus_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bus_out));

    assert_busy_covers_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_req_n |-> busy);

    assert_lowv_in_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vr_lowv_req |-> !sleep_req_n);

    assert_status_after_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(mode_perf) |-> (!busy && sleep_req_n));
endmodule

bind dual_mode_seq dual_mode_seq_chk #(.BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req_n (sleep_req_n),
    .bclk_en     (bclk_en),
    .bclk_p      (bclk_p),
    .bclk_n      (bclk_n),
    .vr_lowv_req (vr_lowv_req),
    .bus_out     (bus_out),
    .busy        (busy),
    .mode_perf   (mode_perf)
);

// File: tb/tb_dual_mode_seq.sv
module tb_dual_mode_seq;
    localparam int VID_W = 5;
    localparam int BUS_W = 8;
    localparam logic [VID_W-1:0] VID_BAT  = 5'h0C;
    localparam logic [VID_W-1:0] VID_PERF = 5'h12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_perf = 1'b0;
    logic             deeper_en = 1'b0;
    logic [VID_W-1:0] vid_in = VID_BAT;
    logic             vr_pgood = 1'b1;
    logic [BUS_W-1:0] bus_in = '0;
    logic             mode_sel_n, sleep_req_n, bclk_en, bclk_p, bclk_n;
    logic [VID_W-1:0] vr_vid;
    logic             vr_lowv_req, busy, err, mode_perf;
    logic [BUS_W-1:0] bus_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dual_mode_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_perf(req_perf),
        .deeper_en(deeper_en), .vid_in(vid_in), .vr_pgood(vr_pgood), .bus_in(bus_in),
        .mode_sel_n(mode_sel_n), .sleep_req_n(sleep_req_n), .bclk_en(bclk_en),
        .bclk_p(bclk_p), .bclk_n(bclk_n), .vr_vid(vr_vid), .vr_lowv_req(vr_lowv_req),
        .bus_out(bus_out), .busy(busy), .err(err), .mode_perf(mode_perf)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_req(input logic perf, input logic deep);
        req_perf  = perf;
        deeper_en = deep;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        deeper_en = 1'b0;
    endtask

    task automatic wait_sleep_low();
        for (int i = 0; i < 200 && sleep_req_n; i++) @(negedge clk);
    endtask

    task automatic wait_clk_off();
        for (int i = 0; i < 200 && bclk_en; i++) @(negedge clk);
    endtask

    task automatic wait_clk_on();
        for (int i = 0; i < 2000 && !bclk_en; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        tick(3);
    endtask

    task automatic test_reset();
        chk("R1 mode_sel_n", mode_sel_n, 1);
        chk("R1 sleep_req_n", sleep_req_n, 1);
        chk("R1 bclk_en", bclk_en, 1);
        chk("R1 mode_perf", mode_perf, 0);
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        chk("R1 lowv", vr_lowv_req, 0);
        bus_in = 8'hA5;
        tick(1);
        chk("R6 bus passthrough", bus_out, 8'hA5);
        chk("R7 vid forward", vr_vid, VID_BAT);
    endtask

    task automatic test_to_perf();
        pulse_req(1'b1, 1'b0);
        chk("R2 select low first", mode_sel_n, 0);
        chk("R2 sleep not yet", sleep_req_n, 1);
        wait_sleep_low();
        chk("R2 sleep asserted", sleep_req_n, 0);
        chk("R4 clock runs at sleep entry", bclk_en, 1);
        chk("R6 busy in sleep", busy, 1);
        chk("R8 no lowv without deeper", vr_lowv_req, 0);
        bus_in = 8'h3C;
        tick(3);
        chk("R6 bus frozen", bus_out, 8'hA5);
        wait_clk_off();
        chk("R4 clock gated", bclk_en, 0);
        tick(2);
        chk("R5 true clock low", bclk_p, 0);
        chk("R5 comp clock high", bclk_n, 1);
        vr_pgood = 1'b0;
        vid_in   = VID_PERF;
        tick(1);
        chk("R7 vid forward new", vr_vid, VID_PERF);
        pulse_req(1'b0, 1'b1);
        tick(40);
        chk("R7 waits for pgood", bclk_en, 0);
        chk("R12 status held in sleep", mode_perf, 0);
        vr_pgood = 1'b1;
        wait_clk_on();
        chk("R4 clock restarted", bclk_en, 1);
        chk("R4 sleep still asserted", sleep_req_n, 0);
        chk("R12 status held at restart", mode_perf, 0);
        wait_idle();
        chk("R2 mode_perf", mode_perf, 1);
        chk("R2 sleep released", sleep_req_n, 1);
        chk("R11 select kept", mode_sel_n, 0);
        chk("R6 bus follows again", bus_out, 8'h3C);
        tick(40);
        chk("R11 no queued sleep", sleep_req_n, 1);
        chk("R11 mode kept", mode_perf, 1);
    endtask

    task automatic test_same_mode();
        pulse_req(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) begin
            if (!sleep_req_n) chk("R10 no sleep", sleep_req_n, 1);
            @(negedge clk);
        end
        chk("R10 mode unchanged", mode_perf, 1);
        chk("R10 select unchanged", mode_sel_n, 0);
        chk("R10 busy low", busy, 0);
    endtask

    task automatic test_to_battery_deeper();
        pulse_req(1'b0, 1'b1);
        chk("R3 select high", mode_sel_n, 1);
        wait_sleep_low();
        chk("R8 lowv with sleep", vr_lowv_req, 1);
        wait_clk_off();
        vid_in = VID_PERF;
        tick(30);
        chk("R7 same vid no wake", bclk_en, 0);
        vid_in = VID_BAT;
        wait_clk_on();
        chk("R8 lowv still high", vr_lowv_req, 1);
        for (int i = 0; i < 200 && !sleep_req_n; i++) @(negedge clk);
        chk("R8 lowv drops with wake", vr_lowv_req, 0);
        wait_idle();
        chk("R3 mode_perf", mode_perf, 0);
        chk("R3 err clear", err, 0);
    endtask

    task automatic test_timeout();
        pulse_req(1'b1, 1'b0);
        chk("R9 select low", mode_sel_n, 0);
        for (int i = 0; i < 3000 && !err; i++) @(negedge clk);
        chk("R9 err set", err, 1);
        chk("R9 select restored", mode_sel_n, 1);
        chk("R9 clock restarted", bclk_en, 1);
        wait_idle();
        chk("R9 sleep released", sleep_req_n, 1);
        chk("R9 mode unchanged", mode_perf, 0);
        chk("R9 err sticky", err, 1);
        pulse_req(1'b1, 1'b0);
        chk("R9 err cleared", err, 0);
        wait_clk_off();
        vid_in = VID_PERF;
        wait_clk_on();
        wait_idle();
        chk("R2 mode_perf after retry", mode_perf, 1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        test_reset();
        test_to_perf();
        test_same_mode();
        test_to_battery_deeper();
        test_timeout();
        summary();
        $finish;
    end
endmodule